// File: doc/BRIEF.md
# CAN Controller Low-Power Sleep/Wakeup Manager

This block manages the low-power mode of a CAN-style bus controller. A host sets a sleep-request bit through a small register interface. The block does not go to sleep at once. While a transmission is still pending it asks the transmit side to abort, and it also waits for any frame reception in progress to end. Only after that does it enter sleep and report this through a read-only acknowledge bit. The host polls that bit before it stops its own clocks.

While asleep, the block watches the raw receive line. The line is first synchronized. A dominant (low) level that lasts a parameterised number of clock cycles counts as bus activity. Shorter pulses are treated as glitches. On bus activity the block wakes by itself: it clears both the request and the acknowledge, and it sets a sticky wakeup flag. That flag drives the interrupt output when the wakeup interrupt is enabled. The frame that caused the wakeup is not expected to be received correctly.

The host can also leave sleep on its own by clearing the request bit, or it can write the soft-reset bit. Register map (address: bits): 0 = control (bit 2 sleep acknowledge, read-only; bit 1 sleep request; bit 0 soft reset, self-clearing); 1 = flag (bit 7 wakeup flag, write 1 to clear); 2 = interrupt enable (bit 7 wakeup interrupt enable). All other bits and address 3 read as zero.

Top module: `can_sleep_ctrl`

## Requirements
- R1: After reset every register reads 0x00, and `tx_abort_req` and `wake_irq` are low. Unimplemented bits read zero even after all-ones writes.
- R2: With `tx_pending` and `rx_busy` low, writing 1 to control bit 1 sets control bit 2 (acknowledge) on the clock edge after the write edge. Control bit 2 ignores writes.
- R3: While control bit 1 is set, the block is not asleep and `tx_pending` is high, `tx_abort_req` is high and acknowledge stays 0. Acknowledge follows once `tx_pending` falls, and `tx_abort_req` then drops.
- R4: While `rx_busy` is high, a pending sleep request is not acknowledged. It is acknowledged after `rx_busy` falls.
- R5: While asleep, a low level on `rx_in` that is seen at DOM_CYCLES or more consecutive clock edges makes the block leave sleep. Control bits 1 and 2 clear and flag bit 7 sets.
- R6: A low pulse on `rx_in` shorter than DOM_CYCLES edges while asleep has no effect. Low levels on `rx_in` while awake never set flag bit 7.
- R7: `wake_irq` is high exactly when flag bit 7 and interrupt-enable bit 7 are both set. The flag is sticky, so enabling the interrupt after a wakeup raises `wake_irq`.
- R8: Writing 1 to flag bit 7 clears the flag and drops `wake_irq`. Writing 0 there leaves the flag unchanged.
- R9: Writing 0 to control bit 1 while asleep or while waiting clears acknowledge at that write edge, and flag bit 7 does not set.
- R10: Writing 1 to control bit 0 clears the request, the acknowledge and flag bit 7, and it leaves the block awake. Control bit 0 reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| rx_in | input | 1 | Raw bus receive line, high is recessive |
| tx_pending | input | 1 | Transmit side still holds a pending or active frame |
| rx_busy | input | 1 | A frame is currently being received |
| tx_abort_req | output | 1 | Request to the transmit side to abort pending frames |
| wake_irq | output | 1 | Wakeup interrupt |

## Verification
The bench sends low pulses around the filter length while the block is asleep. A design with an off-by-one filter would wake on a pulse one cycle short, or would miss a pulse of exactly the threshold length. It keeps `tx_pending` or `rx_busy` high across a sleep request to catch a design that acknowledges too early or never raises the abort. It also lands a host exit, a soft reset and flag clears on top of a sleeping or flagged state. A design that gets those wrong would keep the acknowledge set, leave a stale flag, or set the flag on a host-initiated exit.

// File: rtl/can_sleep_pkg.sv
package can_sleep_pkg;
    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_FLAG = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_IEN  = 2'd2;

    localparam int BIT_SRST = 0;
    localparam int BIT_REQ  = 1;
    localparam int BIT_ACK  = 2;
    localparam int BIT_WUP  = 7;
    localparam int BIT_WIE  = 7;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_DRAIN = 2'd1,
        ST_SLEEP = 2'd2
    } pm_mode_e;

    typedef struct packed {
        pm_mode_e mode;
        logic     req;
        logic     wflag;
        logic     wie;
    } pm_state_t;
endpackage

// File: rtl/can_sleep_rx_filt.sv
module can_sleep_rx_filt #(
    parameter int SYNC_STAGES = 2,
    parameter int DOM_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic rx_i,
    output logic act_o
);
    localparam int CW = $clog2(DOM_CYCLES + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(DOM_CYCLES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
    } filt_t;

    filt_t s_d, s_q;
    logic  line;

    assign line = s_q.sync[SYNC_STAGES-1];

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], rx_i};
        if (!en_i || line) begin
            s_d.cnt = '0;
        end else if (s_q.cnt != CNT_TOP) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    assign act_o = en_i && !line && (s_q.cnt == CNT_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sync <= '1;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: a detection needs the line to have been low, while listening, one cycle earlier too
    assert_short_low_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (DOM_CYCLES > 1 && act_o) |-> $past(en_i && !line));
endmodule

// File: rtl/can_sleep_core.sv
module can_sleep_core
    import can_sleep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [REG_DW-1:0] wr_data_i,
    input  logic              tx_pending_i,
    input  logic              rx_busy_i,
    input  logic              act_i,
    output logic              req_o,
    output logic              ack_o,
    output logic              wflag_o,
    output logic              wie_o,
    output logic              listen_o,
    output logic              abort_o
);
    pm_state_t st_d, st_q;
    logic ctrl_wr, flag_wr, ien_wr, srst_wr, wake_ev;

    assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);
    assign flag_wr = wr_en_i && (wr_addr_i == ADDR_FLAG);
    assign ien_wr  = wr_en_i && (wr_addr_i == ADDR_IEN);
    assign srst_wr = ctrl_wr && wr_data_i[BIT_SRST];
    assign wake_ev = (st_q.mode == ST_SLEEP) && act_i;

    always_comb begin
        st_d = st_q;
        if (ien_wr) begin
            st_d.wie = wr_data_i[BIT_WIE];
        end
        if (flag_wr && wr_data_i[BIT_WUP]) begin
            st_d.wflag = 1'b0;
        end
        unique case (st_q.mode)
            ST_AWAKE, ST_DRAIN: begin
                if (!st_q.req) begin
                    st_d.mode = ST_AWAKE;
                end else if (!tx_pending_i && !rx_busy_i) begin
                    st_d.mode = ST_SLEEP;
                end else begin
                    st_d.mode = ST_DRAIN;
                end
            end
            ST_SLEEP: begin
                if (act_i) begin
                    st_d.mode  = ST_AWAKE;
                    st_d.req   = 1'b0;
                    st_d.wflag = 1'b1;
                end
            end
            default: st_d.mode = ST_AWAKE;
        endcase
        if (ctrl_wr && !wake_ev) begin
            st_d.req = wr_data_i[BIT_REQ];
            if (!wr_data_i[BIT_REQ]) begin
                st_d.mode = ST_AWAKE;
            end
        end
        if (srst_wr) begin
            st_d.mode  = ST_AWAKE;
            st_d.req   = 1'b0;
            st_d.wflag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: ST_AWAKE, req: 1'b0, wflag: 1'b0, wie: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o    = st_q.req;
    assign ack_o    = (st_q.mode == ST_SLEEP);
    assign wflag_o  = st_q.wflag;
    assign wie_o    = st_q.wie;
    assign listen_o = (st_q.mode == ST_SLEEP);
    assign abort_o  = st_q.req && (st_q.mode != ST_SLEEP) && tx_pending_i;

    // R2: being asleep always goes with a standing request
    assert_sleep_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> req_o);
    // R3, R4: acknowledge only rises after a cycle with no transmit and no reception
    assert_ack_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(!tx_pending_i && !rx_busy_i));
    // R5: a wakeup clears request and acknowledge and sets the flag
    assert_wake_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_ev && !srst_wr) |=> (!req_o && !ack_o && wflag_o));
    // R6: the flag only rises out of sleep
    assert_flag_only_from_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wflag_o) |-> $past(st_q.mode == ST_SLEEP));
    // R9: host clearing the request leaves sleep
    assert_host_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data_i[BIT_REQ]) |=> !ack_o);
    // R10: soft reset empties request, acknowledge and flag
    assert_srst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> (!req_o && !ack_o && !wflag_o));
endmodule

// File: rtl/can_sleep_ctrl.sv
module can_sleep_ctrl
    import can_sleep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DOM_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              rx_in,
    input  logic              tx_pending,
    input  logic              rx_busy,
    output logic              tx_abort_req,
    output logic              wake_irq
);
    logic act, listen, req, ack, wflag, wie;

    can_sleep_rx_filt #(
        .SYNC_STAGES(SYNC_STAGES),
        .DOM_CYCLES (DOM_CYCLES)
    ) filt_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en_i (listen),
        .rx_i (rx_in),
        .act_o(act)
    );

    can_sleep_core core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (reg_wr),
        .wr_addr_i   (reg_addr),
        .wr_data_i   (reg_wdata),
        .tx_pending_i(tx_pending),
        .rx_busy_i   (rx_busy),
        .act_i       (act),
        .req_o       (req),
        .ack_o       (ack),
        .wflag_o     (wflag),
        .wie_o       (wie),
        .listen_o    (listen),
        .abort_o     (tx_abort_req)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[BIT_ACK] = ack;
                reg_rdata[BIT_REQ] = req;
            end
            ADDR_FLAG: reg_rdata[BIT_WUP] = wflag;
            ADDR_IEN:  reg_rdata[BIT_WIE] = wie;
            default:   reg_rdata = '0;
        endcase
    end

    assign wake_irq = wflag && wie;

    // R7: disabling the interrupt silences the output from the next cycle on
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_IEN && !reg_wdata[BIT_WIE]) |=> !wake_irq);
endmodule

// File: tb/can_sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module can_sleep_ctrl_tb_top;
    localparam int N  = 4;
    localparam int SS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       rx_in = 1'b1;
    logic       tx_pending = 1'b0;
    logic       rx_busy = 1'b0;
    logic       tx_abort_req;
    logic       wake_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    can_sleep_ctrl #(.SYNC_STAGES(SS), .DOM_CYCLES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_in(rx_in),
        .tx_pending(tx_pending), .rx_busy(rx_busy),
        .tx_abort_req(tx_abort_req), .wake_irq(wake_irq)
    );

    function automatic bit exp_wake(input int len);
        return len >= N;
    endfunction

    function automatic bit exp_irq(input bit flag, input bit en);
        return flag && en;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic low_pulse(input int len);
        rx_in = 1'b0;
        step(len);
        rx_in = 1'b1;
        step(SS + N + 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1'b1;
        step(2);

        // R1 reset state
        rd(0, v); check("R1 ctrl", v, 8'h00);
        rd(1, v); check("R1 flag", v, 8'h00);
        rd(2, v); check("R1 ien", v, 8'h00);
        check("R1 irq/abort", {6'd0, wake_irq, tx_abort_req}, 8'h00);
        wr(2, 8'hFF); wr(1, 8'hFF);
        rd(2, v); check("R1 ien unused bits", v, 8'h80);
        rd(3, v); check("R1 addr3", v, 8'h00);
        wr(2, 8'h00);

        // R2 idle request, acknowledge one edge later; bit 2 ignores writes
        wr(0, 8'h02);
        rd(0, v); check("R2 not yet acked", v, 8'h02);
        step(1);
        rd(0, v); check("R2 acked", v, 8'h06);
        // R9 host exit
        wr(0, 8'h04);
        rd(0, v); check("R9 host exit ctrl", v, 8'h00);
        rd(1, v); check("R9 no flag", v, 8'h00);

        // R3 pending transmit
        tx_pending = 1'b1;
        wr(0, 8'h02);
        step(5);
        rd(0, v); check("R3 held", v, 8'h02);
        check("R3 abort high", {7'd0, tx_abort_req}, 8'h01);
        tx_pending = 1'b0;
        step(2);
        rd(0, v); check("R3 acked", v, 8'h06);
        check("R3 abort low", {7'd0, tx_abort_req}, 8'h00);
        wr(0, 8'h00);

        // R4 receive in progress
        rx_busy = 1'b1;
        wr(0, 8'h02);
        step(5);
        rd(0, v); check("R4 held", v, 8'h02);
        rx_busy = 1'b0;
        step(2);
        rd(0, v); check("R4 acked", v, 8'h06);

        // R6 activity while awake does not set flag; short pulse while asleep ignored
        low_pulse(N - 1);
        rd(0, v); check("R6 short pulse ignored", v, 8'h06);
        wr(0, 8'h00);
        low_pulse(2 * N);
        rd(1, v); check("R6 awake activity", v, 8'h00);

        // R5 exact threshold wakes, R7 sticky flag then enable
        wr(0, 8'h02); step(2);
        low_pulse(N);
        rd(0, v); check("R5 ctrl cleared", v, 8'h00);
        rd(1, v); check("R5 flag set", v, 8'h80);
        check("R7 masked", {7'd0, wake_irq}, 8'h00);
        wr(2, 8'h80);
        check("R7 enabled after wake", {7'd0, wake_irq}, 8'h01);
        // R8 write 0 keeps, write 1 clears
        wr(1, 8'h7F);
        rd(1, v); check("R8 zero write keeps", v, 8'h80);
        wr(1, 8'h80);
        rd(1, v); check("R8 cleared", v, 8'h00);
        check("R8 irq dropped", {7'd0, wake_irq}, 8'h00);

        // R10 soft reset while asleep with flag set
        wr(0, 8'h02); step(2);
        low_pulse(N + 2);
        wr(0, 8'h02); step(2);
        rd(0, v); check("R10 pre asleep", v, 8'h06);
        wr(0, 8'h01);
        rd(0, v); check("R10 ctrl", v, 8'h00);
        rd(1, v); check("R10 flag", v, 8'h00);
        wr(2, 8'h00);

        // random mix
        for (int i = 0; i < 40; i++) begin
            int len = 1 + int'($urandom % (2 * N));
            int dly = int'($urandom % 4);
            bit en  = 1'($urandom % 2);
            bit w;
            wr(2, en ? 8'h80 : 8'h00);
            tx_pending = (dly != 0);
            wr(0, 8'h02);
            if (dly != 0) begin
                step(dly);
                check("R3 rand abort", {7'd0, tx_abort_req}, 8'h01);
                tx_pending = 1'b0;
            end
            step(2);
            rd(0, v); check("R2 rand ack", v, 8'h06);
            low_pulse(len);
            w = exp_wake(len);
            rd(0, v); check(w ? "R5 rand wake" : "R6 rand ignore", v, w ? 8'h00 : 8'h06);
            rd(1, v); check("R5 rand flag", v, w ? 8'h80 : 8'h00);
            check("R7 rand irq", {7'd0, wake_irq}, {7'd0, exp_irq(w, en)});
            wr(1, 8'h80);
            wr(0, 8'h00);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule